// File: doc/BRIEF.md
# Handshaked Disk Command Parameter Collector

This block sits on the peripheral side of a byte-wide host link. The host writes a data byte into a latch, then writes a control byte whose upper bits act as handshake strobes. An attention strobe arms command mode. The next data-valid strobe then takes the latched byte as a command opcode. The opcode fixes how many parameter bytes follow. Each later data-valid strobe stores the latched byte in a small parameter buffer and counts down. When the count reaches zero, the block raises a one-cycle fired pulse.

For the two bulk-transfer opcodes, load (0x0E) and save (0x0F), the block also decodes the collected parameters. It produces the byte offset on the disk image, the transfer size, the drive choice and the target memory address. It does not move any data itself. A downstream engine acts on the fired pulse and the decoded fields.

Top module: `fdc_cmd_collector`

## Requirements
- R1: After reset, every output is zero: latch, accepted flag, armed flag, opcode, remaining count, parameters, reply, fired and transfer pulse.
- R2: The control byte bits that matter are bit 7 (attention) and bit 4 (data valid). A rising attention sets the armed flag. A rising data valid while armed loads the latch into the opcode and clears the armed flag. When both bits rise in one write, data valid is handled with the old armed state and the armed flag ends set.
- R3: On an opcode, the remaining count is loaded from a fixed table: 4 for 0x01, 0x02, 0x08, 0x09, 0x0B and 0x0C; 7 for 0x04; 2 for 0x0D; 6 for 0x0E and 0x0F; 0 for every other value. The buffer index restarts at 0.
- R4: A rising data valid while not armed and with a nonzero count stores the latch at the next buffer index (parameter i is in params_o bits [8i+7:8i]) and decrements the count. The step that reaches zero raises fired_o for exactly one cycle.
- R5: Bytes beyond the six buffer slots are dropped and leave the buffer unchanged. Opcode 0x04 still counts all seven bytes and fires on the seventh.
- R6: A rising data valid with a zero count while not armed stores nothing and does not fire.
- R7: Only rising edges act. A repeated control write that keeps data valid high captures nothing.
- R8: A rising data valid sets the accepted flag. A falling data valid while the flag is set clears both the flag and the data latch.
- R9: Opcode 0x06 sets reply_o to 0x00 and opcode 0x07 sets it to 0x1F. Other opcodes leave it unchanged.
- R10: For 0x0E and 0x0F, the parameters are read as sector count, drive, track, start sector, address high and address low. The block outputs offset = (track*16 + sector - 1)*256 modulo 2^21, size = count*256, drive = (drive byte != 0) and address = high*256 + low. xfer_o pulses together with fired_o, and xfer_save_o is 1 for 0x0F.
- R11: Control bits 0 to 3, 5 and 6 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_data_i | input | 8 | Host data byte |
| host_data_we_i | input | 1 | Writes host_data_i into the latch |
| host_ctrl_i | input | 8 | Host control byte |
| host_ctrl_we_i | input | 1 | Writes host_ctrl_i into the control register |
| data_latch_o | output | 8 | Current data latch |
| accepted_o | output | 1 | Data accepted flag |
| armed_o | output | 1 | Command mode armed |
| opcode_o | output | 8 | Last opcode taken |
| remaining_o | output | 3 | Parameter bytes still expected |
| params_o | output | 48 | Parameter buffer, slot i in bits [8i+7:8i] |
| fired_o | output | 1 | One-cycle pulse when the count reaches zero |
| reply_o | output | 8 | Status reply byte |
| xfer_o | output | 1 | One-cycle pulse on a fired load or save |
| xfer_save_o | output | 1 | Current opcode is save |
| xfer_drive_o | output | 1 | Second drive selected |
| xfer_offset_o | output | 21 | Decoded byte offset |
| xfer_size_o | output | 16 | Decoded transfer size |
| xfer_addr_o | output | 16 | Decoded target address |

## Verification
The bench sweeps all 32 low opcode values. For each one it checks the loaded count, the fired pulse on exactly the last byte and the stored parameters. A wrong count table would fire early, fire late or fire for opcodes that take no parameters. Mishandling the seventh byte of opcode 0x04 would corrupt slot 5 or drop the pulse. A grid of track, sector, count and drive values exercises the load and save decode, so an off-by-one in the sector base or a swapped address byte order shows up at once. Targeted cases cover a repeated data-valid write (a level-sensitive design would capture twice), a combined attention and data-valid write (wrong ordering would leave the block disarmed), and writes of the unused control bits.

// File: rtl/fdc_hs_pkg.sv
package fdc_hs_pkg;

  localparam int CTRL_DV  = 4;
  localparam int CTRL_ATN = 7;
  localparam int CNT_W    = 3;

  localparam logic [7:0] REPLY_STATUS = 8'h00;
  localparam logic [7:0] REPLY_DRIVES = 8'h1F;

  typedef enum logic [7:0] {
    OP_WRITE    = 8'h01,
    OP_READ     = 8'h02,
    OP_COPY     = 8'h04,
    OP_STATUS   = 8'h06,
    OP_DRVSTATE = 8'h07,
    OP_RAMTEST  = 8'h08,
    OP_XMIT2    = 8'h09,
    OP_XMIT1    = 8'h0B,
    OP_RECV     = 8'h0C,
    OP_GO       = 8'h0D,
    OP_LOAD     = 8'h0E,
    OP_SAVE     = 8'h0F
  } opcode_e;

  // Parameter bytes that follow each opcode
  function automatic logic [CNT_W-1:0] param_count(input logic [7:0] op);
    case (op)
      OP_WRITE, OP_READ, OP_RAMTEST, OP_XMIT2, OP_XMIT1, OP_RECV: return 3'd4;
      OP_COPY:          return 3'd7;
      OP_GO:            return 3'd2;
      OP_LOAD, OP_SAVE: return 3'd6;
      default:          return 3'd0;
    endcase
  endfunction

  function automatic logic is_xfer_op(input logic [7:0] op);
    return (op == OP_LOAD) || (op == OP_SAVE);
  endfunction

endpackage

// File: rtl/hs_strobe_detect.sv
module hs_strobe_detect #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [NB-1:0] lvl_i,
  output logic [NB-1:0] rise_o,
  output logic [NB-1:0] fall_o
);
  for (genvar i = 0; i < NB; i++) begin : g_bit
    logic cur_q, old_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q <= 1'b0;
        old_q <= 1'b0;
      end else begin
        if (we_i) cur_q <= lvl_i[i];
        old_q <= cur_q;
      end
    end
    assign rise_o[i] = cur_q & ~old_q;
    assign fall_o[i] = ~cur_q & old_q;
  end
endmodule

// File: rtl/hs_param_buffer.sv
module hs_param_buffer #(
  parameter int NP = 6,
  parameter int DW = 8,
  parameter int IW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [NP*DW-1:0] flat_o
);
  for (genvar i = 0; i < NP; i++) begin : g_slot
    logic [DW-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else if (wr_en_i && (wr_idx_i == IW'(i))) slot_q <= wr_data_i;
    end
    assign flat_o[i*DW +: DW] = slot_q;
  end
endmodule

// File: rtl/hs_xfer_decode.sv
module hs_xfer_decode #(
  parameter int NP    = 6,
  parameter int DW    = 8,
  parameter int SPT   = 16,
  parameter int SB    = 256,
  parameter int OFS_W = 21,
  parameter int SZ_W  = 16,
  parameter int AW    = 16
) (
  input  logic [NP*DW-1:0] params_i,
  output logic             drive_o,
  output logic [OFS_W-1:0] offset_o,
  output logic [SZ_W-1:0]  size_o,
  output logic [AW-1:0]    addr_o
);
  localparam int P_CNT = 0, P_DRV = 1, P_TRK = 2, P_SEC = 3, P_AHI = 4, P_ALO = 5;

  function automatic logic [OFS_W-1:0] sector_offset(input logic [DW-1:0] trk,
                                                     input logic [DW-1:0] sec);
    logic [OFS_W-1:0] idx;
    idx = OFS_W'(trk) * OFS_W'(SPT) + OFS_W'(sec) - OFS_W'(1);
    return idx * OFS_W'(SB);
  endfunction

  function automatic logic [SZ_W-1:0] xfer_size(input logic [DW-1:0] cnt);
    return SZ_W'(cnt) * SZ_W'(SB);
  endfunction

  function automatic logic [AW-1:0] join_addr(input logic [DW-1:0] hi, input logic [DW-1:0] lo);
    return AW'({hi, lo});
  endfunction

  logic [DW-1:0] f_cnt, f_drv, f_trk, f_sec, f_ahi, f_alo;
  assign f_cnt = params_i[P_CNT*DW +: DW];
  assign f_drv = params_i[P_DRV*DW +: DW];
  assign f_trk = params_i[P_TRK*DW +: DW];
  assign f_sec = params_i[P_SEC*DW +: DW];
  assign f_ahi = params_i[P_AHI*DW +: DW];
  assign f_alo = params_i[P_ALO*DW +: DW];

  assign drive_o  = |f_drv;
  assign offset_o = sector_offset(f_trk, f_sec);
  assign size_o   = xfer_size(f_cnt);
  assign addr_o   = join_addr(f_ahi, f_alo);
endmodule

// File: rtl/fdc_cmd_collector.sv
module fdc_cmd_collector
  import fdc_hs_pkg::*;
#(
  parameter int DW           = 8,
  parameter int NPARAM       = 6,
  parameter int SECT_PER_TRK = 16,
  parameter int SECT_BYTES   = 256,
  localparam int IDX_W = $clog2(NPARAM + 1),
  localparam int OFS_W = $clog2((((1 << DW) - 1) * SECT_PER_TRK + (1 << DW)) * SECT_BYTES),
  localparam int SZ_W  = DW + $clog2(SECT_BYTES),
  localparam int AW    = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        host_data_i,
  input  logic                 host_data_we_i,
  input  logic [7:0]           host_ctrl_i,
  input  logic                 host_ctrl_we_i,
  output logic [DW-1:0]        data_latch_o,
  output logic                 accepted_o,
  output logic                 armed_o,
  output logic [DW-1:0]        opcode_o,
  output logic [CNT_W-1:0]     remaining_o,
  output logic [NPARAM*DW-1:0] params_o,
  output logic                 fired_o,
  output logic [DW-1:0]        reply_o,
  output logic                 xfer_o,
  output logic                 xfer_save_o,
  output logic                 xfer_drive_o,
  output logic [OFS_W-1:0]     xfer_offset_o,
  output logic [SZ_W-1:0]      xfer_size_o,
  output logic [AW-1:0]        xfer_addr_o
);
  // Edge events of the two live strobes: index 0 data valid, index 1 attention
  logic [1:0] rise, fall;
  logic dv_rise, dv_fall, atn_rise;

  hs_strobe_detect #(.NB(2)) u_edges (
    .clk(clk), .rst_n(rst_n), .we_i(host_ctrl_we_i),
    .lvl_i({host_ctrl_i[CTRL_ATN], host_ctrl_i[CTRL_DV]}),
    .rise_o(rise), .fall_o(fall)
  );
  assign dv_rise  = rise[0];
  assign dv_fall  = fall[0];
  assign atn_rise = rise[1];

  logic unused_ctrl;
  assign unused_ctrl = ^{host_ctrl_i[6:5], host_ctrl_i[3:0], fall[1]};

  logic [DW-1:0]    latch_q, opcode_q, reply_q;
  logic             accepted_q, armed_q, fired_q, xfer_q;
  logic [CNT_W-1:0] remaining_q;
  logic [IDX_W-1:0] seq_q;

  // Named internal events
  logic take_opcode, take_param, seq_room, store_en, last_param, ack_clear;
  assign take_opcode = dv_rise & armed_q;
  assign take_param  = dv_rise & ~armed_q & (remaining_q != '0);
  assign seq_room    = seq_q < IDX_W'(NPARAM);
  assign store_en    = take_param & seq_room;
  assign last_param  = take_param & (remaining_q == CNT_W'(1));
  assign ack_clear   = dv_fall & accepted_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q    <= '0;
      accepted_q <= 1'b0;
    end else begin
      if (ack_clear)           latch_q <= '0;
      else if (host_data_we_i) latch_q <= host_data_i;
      if (dv_rise)             accepted_q <= 1'b1;
      else if (ack_clear)      accepted_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      opcode_q    <= '0;
      remaining_q <= '0;
      seq_q       <= '0;
      reply_q     <= '0;
      fired_q     <= 1'b0;
      xfer_q      <= 1'b0;
    end else begin
      fired_q <= last_param;
      xfer_q  <= last_param & is_xfer_op(8'(opcode_q));
      if (atn_rise)         armed_q <= 1'b1;
      else if (take_opcode) armed_q <= 1'b0;
      if (take_opcode) begin
        opcode_q    <= latch_q;
        remaining_q <= param_count(8'(latch_q));
        seq_q       <= '0;
        if (8'(latch_q) == OP_STATUS)        reply_q <= DW'(REPLY_STATUS);
        else if (8'(latch_q) == OP_DRVSTATE) reply_q <= DW'(REPLY_DRIVES);
      end else if (take_param) begin
        remaining_q <= remaining_q - CNT_W'(1);
        if (seq_room) seq_q <= seq_q + IDX_W'(1);
      end
    end
  end

  hs_param_buffer #(.NP(NPARAM), .DW(DW), .IW(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en_i(store_en), .wr_idx_i(seq_q),
    .wr_data_i(latch_q), .flat_o(params_o)
  );

  hs_xfer_decode #(
    .NP(NPARAM), .DW(DW), .SPT(SECT_PER_TRK), .SB(SECT_BYTES),
    .OFS_W(OFS_W), .SZ_W(SZ_W), .AW(AW)
  ) u_dec (
    .params_i(params_o), .drive_o(xfer_drive_o), .offset_o(xfer_offset_o),
    .size_o(xfer_size_o), .addr_o(xfer_addr_o)
  );

  assign data_latch_o = latch_q;
  assign accepted_o   = accepted_q;
  assign armed_o      = armed_q;
  assign opcode_o     = opcode_q;
  assign remaining_o  = remaining_q;
  assign fired_o      = fired_q;
  assign reply_o      = reply_q;
  assign xfer_o       = xfer_q;
  assign xfer_save_o  = 8'(opcode_q) == OP_SAVE;
endmodule

// File: rtl/hs_collector_chk.sv
module hs_collector_chk #(
  parameter int DW     = 8,
  parameter int NPARAM = 6,
  parameter int IDX_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dv_rise,
  input logic             dv_fall,
  input logic             atn_rise,
  input logic             armed,
  input logic             accepted,
  input logic [DW-1:0]    latch,
  input logic             fired,
  input logic             xfer,
  input logic [2:0]       remaining,
  input logic [IDX_W-1:0] seq
);
  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fired |=> !fired); // R4
  AST_FIRE_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    fired |-> (remaining == 3'd0) && ($past(remaining) == 3'd1)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    seq <= IDX_W'(NPARAM)); // R5
  AST_ARM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && dv_rise && !atn_rise) |=> !armed); // R2
  AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    atn_rise |=> armed); // R2
  AST_ACK_ON_DV: assert property (@(posedge clk) disable iff (!rst_n)
    dv_rise |=> accepted); // R8
  AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_fall && accepted) |=> (latch == '0) && !accepted); // R8
  AST_XFER_WITH_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> fired); // R10
endmodule

bind fdc_cmd_collector hs_collector_chk #(.DW(DW), .NPARAM(NPARAM), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dv_rise(dv_rise), .dv_fall(dv_fall), .atn_rise(atn_rise),
  .armed(armed_q), .accepted(accepted_q), .latch(latch_q), .fired(fired_q),
  .xfer(xfer_q), .remaining(remaining_q), .seq(seq_q)
);

// File: tb/sim_fdc_cmd_collector.sv
module sim_fdc_cmd_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  hd = '0, hc = '0;
  logic        hd_we = 1'b0, hc_we = 1'b0;
  logic [7:0]  latch, opcode, reply;
  logic        accepted, armed, fired, xfer, xsave, xdrive;
  logic [2:0]  remaining;
  logic [47:0] params;
  logic [20:0] xoff;
  logic [15:0] xsize, xaddr;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fdc_cmd_collector u0 (
    .clk(clk), .rst_n(rst_n), .host_data_i(hd), .host_data_we_i(hd_we),
    .host_ctrl_i(hc), .host_ctrl_we_i(hc_we), .data_latch_o(latch),
    .accepted_o(accepted), .armed_o(armed), .opcode_o(opcode),
    .remaining_o(remaining), .params_o(params), .fired_o(fired), .reply_o(reply),
    .xfer_o(xfer), .xfer_save_o(xsave), .xfer_drive_o(xdrive),
    .xfer_offset_o(xoff), .xfer_size_o(xsize), .xfer_addr_o(xaddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_count(input int op);
    if (op == 4) return 7;
    if (op == 13) return 2;
    if (op == 14 || op == 15) return 6;
    if (op inside {1, 2, 8, 9, 11, 12}) return 4;
    return 0;
  endfunction

  task automatic wr_data(input logic [7:0] v);
    hd = v; hd_we = 1'b1; @(negedge clk); hd_we = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    hc = v; hc_we = 1'b1; @(negedge clk); hc_we = 1'b0; @(negedge clk);
  endtask

  task automatic issue_op(input logic [7:0] op);
    wr_ctrl(8'h80); wr_ctrl(8'h00); wr_data(op); wr_ctrl(8'h10);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic f, output logic x);
    wr_data(v); wr_ctrl(8'h10); f = fired; x = xfer; wr_ctrl(8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic f, x;
    logic [7:0] exp_reply;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 latch", latch, 0);  chk("R1 accepted", accepted, 0);
    chk("R1 armed", armed, 0);  chk("R1 opcode", opcode, 0);
    chk("R1 remaining", remaining, 0); chk("R1 params", params[31:0], 0);
    chk("R1 fired", fired, 0);  chk("R1 reply", reply, 0);  chk("R1 xfer", xfer, 0);

    // R6 data valid with nothing pending
    send_byte(8'h55, f, x);
    chk("R6 no fire idle", f, 0);
    chk("R6 slot0 untouched", params[7:0], 0);

    // Opcode sweep: R2 R3 R4 R5 R6 R8 R9 R10
    exp_reply = 8'h00;
    for (int op = 0; op < 32; op++) begin
      int n;
      n = ref_count(op);
      issue_op(8'(op));
      chk("R2 opcode taken", opcode, op);
      chk("R2 disarmed", armed, 0);
      chk("R8 accepted set", accepted, 1);
      chk("R3 count", remaining, n);
      if (op == 6) exp_reply = 8'h00;
      if (op == 7) exp_reply = 8'h1F;
      chk("R9 reply", reply, exp_reply);
      wr_ctrl(8'h00);
      chk("R8 latch cleared", latch, 0);
      chk("R8 accepted cleared", accepted, 0);
      for (int k = 0; k < n; k++) begin
        send_byte(8'(op * 8 + k + 1), f, x);
        chk("R4 fire on last", f, (k == n - 1));
        chk("R10 xfer pulse", x, (k == n - 1) && (op == 14 || op == 15));
      end
      chk("R4 count drained", remaining, 0);
      for (int i = 0; i < 6; i++)
        if (i < n) chk("R4 R5 slot", params[i*8 +: 8], 8'(op * 8 + i + 1));
      if (n == 0) begin
        send_byte(8'hA5, f, x);
        chk("R6 no fire after zero count", f, 0);
      end
    end

    // R10 decode grid
    for (int t = 0; t < 4; t++) begin
      for (int s = 0; s < 3; s++) begin
        int trk, sec, cnt, drv, expo;
        trk = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 39 : 255;
        sec = (s == 0) ? 1 : (s == 1) ? 16 : 255;
        cnt = t * 40 + s + 1;
        drv = s % 2;
        issue_op((s == 1) ? 8'h0F : 8'h0E);
        wr_ctrl(8'h00);
        send_byte(8'(cnt), f, x);
        send_byte(8'(drv), f, x);
        send_byte(8'(trk), f, x);
        send_byte(8'(sec), f, x);
        send_byte(8'(t + 16), f, x);
        send_byte(8'(s + 200), f, x);
        expo = ((trk * 16 + sec - 1) * 256) & 32'h1FFFFF;
        chk("R10 fired", f, 1);
        chk("R10 offset", xoff, expo);
        chk("R10 size", xsize, cnt * 256);
        chk("R10 addr", xaddr, (t + 16) * 256 + s + 200);
        chk("R10 drive", xdrive, drv != 0);
        chk("R10 save flag", xsave, s == 1);
      end
    end

    // R7 repeated level does not recapture
    issue_op(8'h0D); wr_ctrl(8'h00);
    send_byte(8'h31, f, x);
    chk("R7 first byte", remaining, 1);
    wr_data(8'h32); wr_ctrl(8'h10);
    chk("R7 first rise", remaining, 0);
    wr_data(8'h33); wr_ctrl(8'h10);
    chk("R7 held level no capture", params[15:8], 8'h32);
    chk("R7 no second fire", fired, 0);
    wr_ctrl(8'h00);

    // R11 unused control bits
    issue_op(8'h01); wr_ctrl(8'h00);
    wr_data(8'h77);
    wr_ctrl(8'h6F);
    chk("R11 count unchanged", remaining, 4);
    chk("R11 accepted unchanged", accepted, 0);
    chk("R11 armed unchanged", armed, 0);
    chk("R11 latch kept", latch, 8'h77);
    wr_ctrl(8'h00);

    // R2 attention and data valid together
    issue_op(8'h00); wr_ctrl(8'h00);
    wr_data(8'h0D);
    wr_ctrl(8'h90);
    chk("R2 combined arms", armed, 1);
    chk("R2 combined opcode kept", opcode, 0);
    wr_ctrl(8'h00);
    wr_data(8'h0C); wr_ctrl(8'h10);
    chk("R2 opcode after combined", opcode, 8'h0C);
    chk("R3 count after combined", remaining, 4);
    wr_ctrl(8'h00);

    // R9 status opcode again
    issue_op(8'h07); chk("R9 drive state", reply, 8'h1F); wr_ctrl(8'h00);
    issue_op(8'h06); chk("R9 status", reply, 8'h00); wr_ctrl(8'h00);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule